// File: doc/BRIEF.md
# Sleep Controller with Guarded Brown-Out Disable

This block is a slice of a microcontroller's system-control logic. It holds one 8-bit sleep-control register. That register carries a sleep-enable bit, a two-bit sleep-mode field, an unlock bit and a brown-out-off bit. Software can switch the brown-out detector off for a single sleep period only. To do so it first arms an unlock with one register write. A second write must then follow within a short window. The brown-out-off request turns active a fixed number of cycles after that second write, and it withdraws by itself a few cycles later.

A sleep-instruction pulse from the CPU is compared against that short active interval. If sleep is enabled and the request is active, the `bod_off` output rises and gates the analog detector off. It stays high until a wake event arrives. After that, each later sleep needs a fresh unlock sequence. A build parameter can leave the whole feature out. The guarded bits then read zero, and `bod_off` never rises.

Top module: `sleep_bod_ctrl`

## Requirements
- R1: After reset, `rd_data` reads 0x00 and `bod_off` is low.
- R2: Bit 5 (sleep enable) and bits 4:3 (sleep mode, 2'b10 = power-down) take the written data on every register write, whatever state the unlock is in. Bits 6, 1 and 0 always read 0.
- R3: A write with data bit 7 = 1 and bit 2 = 1 arms the unlock. Bit 2 then reads 1 in the four cycles that follow this write, and it clears by itself after them.
- R4: While the unlock is armed, a write with bit 7 = 1 and bit 2 = 0 sets bit 7. This write must land on one of the four clock edges after the arming write. A write with bit 7 = 1 that arrives outside that window leaves bit 7 clear.
- R5: Any other write during the window aborts the sequence. Bit 2 clears and bit 7 stays clear. A new arming write starts the sequence again.
- R6: Once set, bit 7 reads 1 for six cycles and then clears by itself. It is active only in its last three cycles. A sleep pulse on the 4th, 5th or 6th clock edge after the setting write finds it active. A pulse on the 3rd or 7th edge does not.
- R7: A sleep pulse with sleep enabled while bit 7 is active raises `bod_off` on that edge. `bod_off` holds until `wake`, and it is low one edge after `wake`. When `wake` and a sleep pulse meet on the same edge, `wake` wins.
- R8: A sleep pulse while sleep enable is 0 is ignored, and `bod_off` stays low.
- R9: A sleep pulse outside the active interval of bit 7 leaves `bod_off` low.
- R10: With `HAS_BOD_OFF` = 0, bits 7 and 2 always read 0, the arming and setting writes have no effect, and `bod_off` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Current register contents |
| slp_req | input | 1 | One-cycle pulse from the CPU sleep instruction |
| wake | input | 1 | Wake event that ends the sleep period |
| bod_off | output | 1 | High while the brown-out detector is to be gated off |

## Verification
The bench targets the edges of both windows. A second write is placed on the 4th and the 5th edge after arming, and a sleep pulse on the 3rd, 4th, 6th and 7th edge after the setting write. A counter that is off by one in either window would raise `bod_off` on a pulse that came too late, or drop one that came in time. Other directed cases cover an aborting write and the restart after it, a bare write of bit 7 with no unlock, a sleep pulse with sleep enable clear, and `wake` arriving together with a sleep pulse. A design that let any write reach bit 7, ignored sleep enable, or let a sleep pulse override `wake` would leave `bod_off` high where the bench expects it low. A second instance built without the feature shows whether the guarded bits really read zero.

// File: rtl/slp_pkg.sv
package slp_pkg;
  localparam int REG_W   = 8;
  localparam int B_BOFF  = 7;
  localparam int B_SE    = 5;
  localparam int B_MODEH = 4;
  localparam int B_MODEL = 3;
  localparam int B_UNLK  = 2;

  typedef struct packed {
    logic       se;
    logic [1:0] mode;
  } slp_fields_t;
endpackage

// File: rtl/slp_rst_sync.sv
module slp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/slp_unlock.sv
module slp_unlock
  import slp_pkg::*;
#(
  parameter int WIN_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic             unlk,
  output logic             accept
);
  localparam int CW = $clog2(WIN_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          is_arm, is_fin;

  always_comb begin
    is_arm = wr_en & wr_data[B_BOFF] & wr_data[B_UNLK];
    is_fin = wr_en & wr_data[B_BOFF] & ~wr_data[B_UNLK] & (cnt_q != '0);
    cnt_d  = cnt_q;
    if (wr_en) begin
      cnt_d = is_arm ? CW'(WIN_CYC) : '0;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign unlk   = (cnt_q != '0);
  assign accept = is_fin;

  AST_WINDOW_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R3
endmodule

// File: rtl/slp_bodflag.sv
module slp_bodflag #(
  parameter int DLY_CYC  = 3,
  parameter int HOLD_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic flag_set,
  output logic flag_act
);
  localparam int TOT = DLY_CYC + HOLD_CYC;
  localparam int DW  = $clog2(TOT + 1);

  logic [DW-1:0] dcnt_q, dcnt_d;

  always_comb begin
    dcnt_d = dcnt_q;
    if (load)                dcnt_d = DW'(TOT);
    else if (dcnt_q != '0)   dcnt_d = dcnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dcnt_q <= '0;
    else        dcnt_q <= dcnt_d;
  end

  assign flag_set = (dcnt_q != '0);
  assign flag_act = flag_set && (dcnt_q <= DW'(HOLD_CYC));

  AST_CLEARS_AFTER_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_set) |-> $past(flag_act)); // R6
  AST_LOAD_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (flag_set && !flag_act)); // R6
endmodule

// File: rtl/sleep_bod_ctrl.sv
module sleep_bod_ctrl
  import slp_pkg::*;
#(
  parameter bit HAS_BOD_OFF = 1'b1,
  parameter int WIN_CYC     = 4,
  parameter int DLY_CYC     = 3,
  parameter int HOLD_CYC    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             slp_req,
  input  logic             wake,
  output logic             bod_off
);
  logic        rst_s;
  slp_fields_t fld_q, fld_d;
  logic        unlk, accept, b_set, b_act;
  logic        off_q, off_d;

  slp_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_s)
  );

  generate
    if (HAS_BOD_OFF) begin : g_feat
      slp_unlock #(.WIN_CYC(WIN_CYC)) u_unlock (
        .clk(clk), .rst_n(rst_s), .wr_en(wr_en), .wr_data(wr_data),
        .unlk(unlk), .accept(accept)
      );
      slp_bodflag #(.DLY_CYC(DLY_CYC), .HOLD_CYC(HOLD_CYC)) u_flag (
        .clk(clk), .rst_n(rst_s), .load(accept),
        .flag_set(b_set), .flag_act(b_act)
      );
    end else begin : g_nofeat
      assign unlk   = 1'b0;
      assign accept = 1'b0;
      assign b_set  = 1'b0;
      assign b_act  = 1'b0;
    end
  endgenerate

  always_comb begin
    fld_d = fld_q;
    if (wr_en) begin
      fld_d.se   = wr_data[B_SE];
      fld_d.mode = wr_data[B_MODEH:B_MODEL];
    end
  end

  always_comb begin
    off_d = off_q;
    if (wake)                          off_d = 1'b0;
    else if (slp_req && fld_q.se && b_act) off_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      fld_q <= '0;
      off_q <= 1'b0;
    end else begin
      fld_q <= fld_d;
      off_q <= off_d;
    end
  end

  always_comb begin
    rd_data          = '0;
    rd_data[B_BOFF]  = b_set;
    rd_data[B_SE]    = fld_q.se;
    rd_data[B_MODEH:B_MODEL] = fld_q.mode;
    rd_data[B_UNLK]  = unlk;
  end

  assign bod_off = off_q;

  AST_WAKE_DROPS_OFF: assert property (@(posedge clk) disable iff (!rst_s)
    wake |=> !bod_off); // R7
  AST_OFF_NEEDS_SE: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(bod_off) |-> ($past(fld_q.se) && $past(slp_req))); // R8
  AST_OFF_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(bod_off) |-> $past(b_act)); // R9
  AST_NOFEAT_QUIET: assert property (@(posedge clk) disable iff (!rst_s)
    !HAS_BOD_OFF |-> (!bod_off && !rd_data[B_BOFF] && !rd_data[B_UNLK])); // R10
endmodule

// File: tb/sleep_bod_ctrl_test.sv
module sleep_bod_ctrl_test;
  localparam int CLK_PER = 10;

  // row: [8:5] edges from arming to setting write, [4:1] edges from setting write to sleep, [0] expected bod_off
  localparam logic [8:0] VEC [8] = '{
    {4'd1, 4'd4, 1'b1}, {4'd4, 4'd4, 1'b1}, {4'd5, 4'd4, 1'b0}, {4'd2, 4'd3, 1'b0},
    {4'd2, 4'd6, 1'b1}, {4'd2, 4'd7, 1'b0}, {4'd3, 4'd5, 1'b1}, {4'd4, 4'd6, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, slp_req, wake;
  logic [7:0] wr_data;
  logic [7:0] rd_data, rd_nf;
  logic       bod_off, bod_nf;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  sleep_bod_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .slp_req(slp_req), .wake(wake), .bod_off(bod_off)
  );

  sleep_bod_ctrl #(.HAS_BOD_OFF(1'b0)) uut_nf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_nf),
    .slp_req(slp_req), .wake(wake), .bod_off(bod_nf)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input logic s, input logic w);
    slp_req = s; wake = w;
    @(negedge clk);
    slp_req = 1'b0; wake = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = 8'h00; slp_req = 1'b0; wake = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    chk(rd_data, 8'h00, "R1 reset value");
    chk({7'd0, bod_off}, 8'h00, "R1 reset bod_off");

    wr(8'h7B);
    chk(rd_data, 8'h38, "R2 plain write");
    chk(rd_nf, 8'h38, "R10 plain write");
    wr(8'h00);
    chk(rd_data, 8'h00, "R2 clear write");

    wr(8'h84);
    chk(rd_data, 8'h04, "R3 unlock after arm");
    for (int i = 0; i < 3; i++) begin
      idle(1);
      chk(rd_data, 8'h04, "R3 unlock held");
    end
    idle(1);
    chk(rd_data, 8'h00, "R3 unlock self-clear");

    wr(8'h80);
    chk(rd_data, 8'h00, "R4 bare set write");

    wr(8'hB4);
    chk(rd_nf, 8'h30, "R10 arm ignored");
    wr(8'h30);
    chk(rd_data, 8'h30, "R5 abort clears unlock");
    wr(8'hB0);
    chk(rd_data, 8'h30, "R5 set after abort");
    wr(8'hB4);
    wr(8'hB0);
    chk(rd_data, 8'hB0, "R5 restart sets bit");
    chk(rd_nf, 8'h30, "R10 set ignored");
    idle(5);
    chk(rd_data, 8'hB0, "R6 bit held");
    idle(1);
    chk(rd_data, 8'h30, "R6 bit self-clear");

    wr(8'h94);
    wr(8'h90);
    idle(3);
    pulse(1'b1, 1'b0);
    chk({7'd0, bod_off}, 8'h00, "R8 sleep with SE clear");

    wr(8'hB4);
    wr(8'hB0);
    idle(3);
    pulse(1'b1, 1'b0);
    chk({7'd0, bod_off}, 8'h01, "R7 accepted sleep");
    idle(5);
    chk({7'd0, bod_off}, 8'h01, "R7 held while asleep");
    pulse(1'b0, 1'b1);
    chk({7'd0, bod_off}, 8'h00, "R7 wake clears");
    idle(3);

    wr(8'hB4);
    wr(8'hB0);
    idle(3);
    pulse(1'b1, 1'b1);
    chk({7'd0, bod_off}, 8'h00, "R7 wake wins");
    idle(6);

    for (int r = 0; r < 8; r++) begin
      wr(8'hB4);
      idle(int'(VEC[r][8:5]) - 1);
      wr(8'hB0);
      idle(int'(VEC[r][4:1]) - 1);
      pulse(1'b1, 1'b0);
      chk({7'd0, bod_off}, {7'd0, VEC[r][0]}, "R4 R6 R9 window row");
      chk({7'd0, bod_nf}, 8'h00, "R10 no bod_off");
      pulse(1'b0, 1'b1);
      idle(8);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule